// File: doc/BRIEF.md
# Dual-Rail Start-Up Sequencer with Latched Fault Shutdown

This controller brings up a positive and a negative supply rail in a fixed order and then guards them. When the enable line goes high, the positive converter switches on at once with its switch current limit reduced. After a start window of 10 ms, the block checks the comparator flags. If they are good, the negative converter switches on at its default setpoint. After 20 ms from enable, the negative rail must report that it is in regulation. If it does, the block enters steady operation.

In steady operation, a persistence filter watches a low-fault flag on the positive rail and a drift-high flag on the negative rail. A flag held for 3 ms trips the block. Flags that clear sooner are ignored. A start-up fault, a run-time trip or over-temperature switches off both converters and latches a fault state. While the block is off or faulted it asks for the outputs to be discharged. The latch clears only when undervoltage lockout asserts, or when enable is taken low. A later rise of enable restarts the sequence.

All time windows are given in milliseconds and scaled by the clock rate in kHz. This means one netlist serves any clock.

Top module: `rail_seq_supervisor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pos_en_o`, `neg_en_o`, `soft_o` and `fault_o` are 0 and `dischg_o` is 1.
- R2: From off, with `en_i`=1, `uvlo_i`=0 and `otemp_i`=0 sampled at a clock edge, `pos_en_o` and `soft_o` are 1 after that edge and `neg_en_o` stays 0.
- R3: Counting from the edge that started the sequence, at edge START_MS*CLK_KHZ the block checks `pos_reg_i`=1 and `neg_thr_i`=0. If both hold, `neg_en_o` becomes 1 and `soft_o` becomes 0 after that edge, and not one edge earlier.
- R4: If `pos_reg_i`=0 at that start deadline edge, the block latches a fault.
- R5: If `neg_thr_i`=1 at that start deadline edge, the block latches a fault.
- R6: At edge NEG_CHECK_MS*CLK_KHZ after the sequence started, `neg_reg_i`=0 latches a fault. `neg_reg_i`=1 enters steady operation with both enables kept at 1.
- R7: In steady operation, `pos_low_i` held high for PERSIST_MS*CLK_KHZ consecutive edges latches a fault after the last of them. A run one edge shorter, followed by a low, has no effect.
- R8: The same holds for `neg_drift_i` on the negative rail, with the same window.
- R9: `otemp_i`=1 while a rail is enabled, or at the moment of enabling from off, latches a fault after the next edge.
- R10: While faulted, `fault_o`=1 and `dischg_o`=1, with both enables and `soft_o` at 0. This state holds as long as `en_i`=1 and `uvlo_i`=0, whatever the rail flags do.
- R11: A fault clears (`fault_o`=0) one edge after `uvlo_i`=1 or `en_i`=0 is sampled. With `en_i` high and `uvlo_i` low again, the sequence restarts per R2.
- R12: `uvlo_i`=1 or `en_i`=0 during any start-up phase or steady operation turns both enables off after the next edge, with `dischg_o`=1 and `fault_o`=0.
- R13: `pos_low_i` and `neg_drift_i` have no effect during the start-up phases, even when held longer than the persistence window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable line |
| uvlo_i | input | 1 | Undervoltage lockout flag |
| otemp_i | input | 1 | Over-temperature flag |
| pos_reg_i | input | 1 | Positive rail in regulation |
| pos_low_i | input | 1 | Positive rail below fault level |
| neg_thr_i | input | 1 | Negative rail above start threshold |
| neg_reg_i | input | 1 | Negative rail in regulation |
| neg_drift_i | input | 1 | Negative rail drifted above its nominal |
| pos_en_o | output | 1 | Positive converter enable |
| neg_en_o | output | 1 | Negative converter enable |
| dischg_o | output | 1 | Output discharge request |
| soft_o | output | 1 | Reduced current limit on the positive converter |
| fault_o | output | 1 | Fault latched |

## Verification
Every output is decoded from the state register, so each result moves exactly one edge after the input that causes it is sampled. The enables respond to enable, lockout and over-temperature after one edge. The two deadlines land at edge START_MS*CLK_KHZ and edge NEG_CHECK_MS*CLK_KHZ after the edge that began the sequence. A persistence trip appears after the PERSIST_MS*CLK_KHZ-th consecutive sampled high. The bench drives inputs 1 ns after a rising edge and samples after exactly that many edges. At each deadline it also checks the edge just before, so an off-by-one in either direction is caught.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

   typedef enum logic [2:0] {
      ST_OFF       = 3'd0,
      ST_START_POS = 3'd1,
      ST_START_NEG = 3'd2,
      ST_RUN       = 3'd3,
      ST_FAULT     = 3'd4
   } rail_state_t;

   localparam int unsigned RAIL_POS = 0;
   localparam int unsigned RAIL_NEG = 1;
   localparam int unsigned N_RAILS  = 2;

   function automatic int unsigned ms_to_cycles(input int unsigned khz,
                                                input int unsigned ms);
      return khz * ms;
   endfunction

endpackage

// File: rtl/rsup_elapsed.sv
module rsup_elapsed #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_w
         $error("rsup_elapsed: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && (cnt != TOP))
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/rsup_persist.sv
module rsup_persist #(
   parameter int unsigned LIMIT = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic flag,
   output logic trip
);

   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("rsup_persist: LIMIT must be at least 2 cycles");
      end
   endgenerate

   logic [CW-1:0] run_len;
   logic          at_last;

   assign at_last = (run_len == LAST);
   assign trip    = arm && flag && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_len <= '0;
      else if (!arm || !flag)
         run_len <= '0;
      else if (!at_last)
         run_len <= run_len + 1'b1;
   end

endmodule

// File: rtl/rsup_fsm.sv
module rsup_fsm
   import rsup_pkg::*;
#(
   parameter int unsigned W        = 12,
   parameter int unsigned DLY_CYC  = 1000,
   parameter int unsigned CHK_CYC  = 2000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic         uvlo_i,
   input  logic         otemp_i,
   input  logic         pos_reg_i,
   input  logic         neg_thr_i,
   input  logic         neg_reg_i,
   input  logic         rt_trip_i,
   input  logic [W-1:0] elapsed_i,
   output rail_state_t  state_o,
   output logic         tmr_inc_o,
   output logic         tmr_clr_o,
   output logic         run_o
);

   localparam logic [W-1:0] DLY_LAST = W'(DLY_CYC - 1);
   localparam logic [W-1:0] CHK_LAST = W'(CHK_CYC - 1);

   generate
      if (CHK_CYC <= DLY_CYC) begin : g_bad_order
         $error("rsup_fsm: regulation deadline must follow the start window");
      end
      if (DLY_CYC < 2) begin : g_bad_dly
         $error("rsup_fsm: start window too short");
      end
   endgenerate

   rail_state_t st, nxt;
   logic        hit_dly, hit_chk, stop_req, start_bad;

   assign hit_dly   = (elapsed_i == DLY_LAST);
   assign hit_chk   = (elapsed_i == CHK_LAST);
   assign stop_req  = uvlo_i || !en_i;
   assign start_bad = !pos_reg_i || neg_thr_i;

   always_comb begin
      nxt = st;
      if (st == ST_OFF) begin
         if (!stop_req)
            nxt = otemp_i ? ST_FAULT : ST_START_POS;
      end else if (st == ST_FAULT) begin
         if (stop_req)
            nxt = ST_OFF;
      end else if (stop_req) begin
         nxt = ST_OFF;
      end else if (otemp_i) begin
         nxt = ST_FAULT;
      end else if (st == ST_START_POS) begin
         if (hit_dly)
            nxt = start_bad ? ST_FAULT : ST_START_NEG;
      end else if (st == ST_START_NEG) begin
         if (hit_chk)
            nxt = neg_reg_i ? ST_RUN : ST_FAULT;
      end else if (st == ST_RUN) begin
         if (rt_trip_i)
            nxt = ST_FAULT;
      end else begin
         nxt = ST_OFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= ST_OFF;
      else
         st <= nxt;
   end

   assign state_o   = st;
   assign tmr_inc_o = (st == ST_START_POS) || (st == ST_START_NEG);
   assign tmr_clr_o = !tmr_inc_o;
   assign run_o     = (st == ST_RUN);

endmodule

// File: rtl/rail_seq_supervisor.sv
module rail_seq_supervisor
   import rsup_pkg::*;
#(
   parameter int unsigned CLK_KHZ      = 100,
   parameter int unsigned START_MS     = 10,
   parameter int unsigned NEG_CHECK_MS = 20,
   parameter int unsigned PERSIST_MS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic uvlo_i,
   input  logic otemp_i,
   input  logic pos_reg_i,
   input  logic pos_low_i,
   input  logic neg_thr_i,
   input  logic neg_reg_i,
   input  logic neg_drift_i,
   output logic pos_en_o,
   output logic neg_en_o,
   output logic dischg_o,
   output logic soft_o,
   output logic fault_o
);

   localparam int unsigned DLY_CYC  = ms_to_cycles(CLK_KHZ, START_MS);
   localparam int unsigned CHK_CYC  = ms_to_cycles(CLK_KHZ, NEG_CHECK_MS);
   localparam int unsigned PER_CYC  = ms_to_cycles(CLK_KHZ, PERSIST_MS);
   localparam int unsigned TW       = $clog2(CHK_CYC + 1);

   generate
      if (CLK_KHZ == 0) begin : g_bad_clk
         $error("rail_seq_supervisor: CLK_KHZ must be nonzero");
      end
      if (PERSIST_MS == 0) begin : g_bad_persist
         $error("rail_seq_supervisor: PERSIST_MS must be nonzero");
      end
   endgenerate

   rail_state_t         state;
   logic [TW-1:0]       elapsed;
   logic                tmr_inc, tmr_clr, in_run;
   logic [N_RAILS-1:0]  rt_flag, rt_trip;

   assign rt_flag[RAIL_POS] = pos_low_i;
   assign rt_flag[RAIL_NEG] = neg_drift_i;

   rsup_elapsed #(.W(TW)) u_elapsed (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .inc   (tmr_inc),
      .cnt   (elapsed)
   );

   for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
      rsup_persist #(.LIMIT(PER_CYC)) u_persist (
         .clk   (clk),
         .rst_n (rst_n),
         .arm   (in_run),
         .flag  (rt_flag[r]),
         .trip  (rt_trip[r])
      );
   end

   rsup_fsm #(
      .W       (TW),
      .DLY_CYC (DLY_CYC),
      .CHK_CYC (CHK_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i),
      .uvlo_i    (uvlo_i),
      .otemp_i   (otemp_i),
      .pos_reg_i (pos_reg_i),
      .neg_thr_i (neg_thr_i),
      .neg_reg_i (neg_reg_i),
      .rt_trip_i (|rt_trip),
      .elapsed_i (elapsed),
      .state_o   (state),
      .tmr_inc_o (tmr_inc),
      .tmr_clr_o (tmr_clr),
      .run_o     (in_run)
   );

   assign pos_en_o = (state == ST_START_POS) || (state == ST_START_NEG) || (state == ST_RUN);
   assign neg_en_o = (state == ST_START_NEG) || (state == ST_RUN);
   assign soft_o   = (state == ST_START_POS);
   assign fault_o  = (state == ST_FAULT);
   assign dischg_o = (state == ST_OFF) || (state == ST_FAULT);

endmodule

// File: rtl/rail_seq_supervisor_chk.sv
module rail_seq_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic uvlo_i,
   input logic otemp_i,
   input logic pos_en_o,
   input logic neg_en_o,
   input logic dischg_o,
   input logic soft_o,
   input logic fault_o
);

   a_r2_start_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (!pos_en_o && !fault_o && en_i && !uvlo_i && !otemp_i)
      |=> (pos_en_o && soft_o && !neg_en_o));

   a_r3_neg_after_pos: assert property (@(posedge clk) disable iff (!rst_n)
      neg_en_o |-> (pos_en_o && !soft_o));

   a_r3_neg_rises_from_soft: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(neg_en_o) |-> $past(soft_o));

   a_r9_otemp_trips: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_en_o && en_i && !uvlo_i && otemp_i) |=> fault_o);

   a_r10_fault_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!pos_en_o && !neg_en_o && dischg_o && !soft_o));

   a_r10_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && en_i && !uvlo_i) |=> fault_o);

   a_r11_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !en_i) |=> !fault_o);

   a_r12_uvlo_stops: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_i |=> (!pos_en_o && !neg_en_o && !fault_o && dischg_o));

endmodule

bind rail_seq_supervisor rail_seq_supervisor_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_i     (en_i),
   .uvlo_i   (uvlo_i),
   .otemp_i  (otemp_i),
   .pos_en_o (pos_en_o),
   .neg_en_o (neg_en_o),
   .dischg_o (dischg_o),
   .soft_o   (soft_o),
   .fault_o  (fault_o)
);

// File: tb/rail_seq_supervisor_tb_top.sv
`timescale 1ns/1ps
module rail_seq_supervisor_tb_top;

   localparam int KHZ = 10;
   localparam int D10 = KHZ * 10;
   localparam int D20 = KHZ * 20;
   localparam int P   = KHZ * 3;

   // vector fields: [4] pos_reg, [3] neg_thr, [2] neg_reg, [1] fault at start deadline, [0] fault at regulation deadline
   localparam logic [4:0] VEC [0:4] = '{
      5'b10100,
      5'b00110,
      5'b11110,
      5'b10001,
      5'b01010
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 0, uvlo_i = 0, otemp_i = 0;
   logic pos_reg_i = 0, pos_low_i = 0, neg_thr_i = 0, neg_reg_i = 0, neg_drift_i = 0;
   logic pos_en_o, neg_en_o, dischg_o, soft_o, fault_o;
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   always #5 clk = ~clk;

   rail_seq_supervisor #(.CLK_KHZ(KHZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i), .otemp_i(otemp_i),
      .pos_reg_i(pos_reg_i), .pos_low_i(pos_low_i), .neg_thr_i(neg_thr_i),
      .neg_reg_i(neg_reg_i), .neg_drift_i(neg_drift_i),
      .pos_en_o(pos_en_o), .neg_en_o(neg_en_o), .dischg_o(dischg_o),
      .soft_o(soft_o), .fault_o(fault_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // outputs packed as {pos_en, neg_en, dischg, soft, fault}
   function automatic logic [4:0] outs();
      return {pos_en_o, neg_en_o, dischg_o, soft_o, fault_o};
   endfunction

   task automatic bring_up();
      en_i = 1;
      edges(D20);
      chk("R6 run entered", outs(), 5'b11000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #2;
      chk("R1 reset outputs", outs(), 5'b00100);
      edges(3);
      chk("R1 held in reset", outs(), 5'b00100);
      rst_n = 1;
      edges(1);
      chk("R1 after release", outs(), 5'b00100);

      // table of start-up scenarios
      for (int i = 0; i < 5; i++) begin
         pos_reg_i = VEC[i][4];
         neg_thr_i = VEC[i][3];
         neg_reg_i = VEC[i][2];
         en_i = 1;
         edges(1);
         chk("R2 positive rail on", outs(), 5'b10010);
         edges(D10 - 1);
         chk("R3 negative rail not yet", outs(), 5'b10010);
         edges(1);
         if (VEC[i][1])
            chk("R4 R5 start deadline fault", outs(), 5'b00101);
         else
            chk("R3 negative rail on", outs(), 5'b11000);
         if (!VEC[i][1]) begin
            edges(D20 - D10 - 1);
            chk("R6 before regulation deadline", outs(), 5'b11000);
            edges(1);
            chk("R6 regulation deadline", outs(), VEC[i][0] ? 5'b00101 : 5'b11000);
         end
         en_i = 0;
         edges(1);
         chk("R11 R12 enable low", outs(), 5'b00100);
         edges(2);
      end

      // R13 runtime flags ignored during start-up, then R7 glitch and trip
      pos_reg_i = 1; neg_thr_i = 0; neg_reg_i = 1;
      pos_low_i = 1; neg_drift_i = 1;
      bring_up();
      pos_low_i = 0; neg_drift_i = 0;
      edges(2 * P);
      chk("R13 start-phase flags ignored", outs(), 5'b11000);
      pos_low_i = 1;
      edges(P - 1);
      pos_low_i = 0;
      edges(2);
      chk("R7 short glitch ignored", outs(), 5'b11000);
      pos_low_i = 1;
      edges(P - 1);
      chk("R7 one short of window", outs(), 5'b11000);
      edges(1);
      chk("R7 positive low trip", outs(), 5'b00101);
      pos_low_i = 0;

      // R10 hold while flags change, R11 clear by lockout and restart
      pos_reg_i = 0; neg_reg_i = 0; neg_thr_i = 1;
      edges(5);
      chk("R10 fault held", outs(), 5'b00101);
      pos_reg_i = 1; neg_reg_i = 1; neg_thr_i = 0;
      uvlo_i = 1;
      edges(1);
      chk("R11 lockout clears fault", outs(), 5'b00100);
      uvlo_i = 0;
      edges(1);
      chk("R11 restart after lockout", outs(), 5'b10010);
      edges(D20 - 1);
      chk("R6 run again", outs(), 5'b11000);

      // R8 negative drift
      neg_drift_i = 1;
      edges(P - 1);
      neg_drift_i = 0;
      edges(2);
      chk("R8 short drift ignored", outs(), 5'b11000);
      neg_drift_i = 1;
      edges(P);
      chk("R8 negative drift trip", outs(), 5'b00101);
      neg_drift_i = 0;
      en_i = 0;
      edges(1);
      chk("R11 enable low clears fault", outs(), 5'b00100);

      // R9 over-temperature in start-up
      en_i = 1;
      edges(3);
      otemp_i = 1;
      edges(1);
      chk("R9 otemp during start", outs(), 5'b00101);
      otemp_i = 0;
      edges(3);
      chk("R10 latch after otemp clears", outs(), 5'b00101);
      en_i = 0;
      edges(1);
      chk("R11 cleared", outs(), 5'b00100);
      otemp_i = 1; en_i = 1;
      edges(1);
      chk("R9 otemp at enable", outs(), 5'b00101);
      otemp_i = 0; en_i = 0;
      edges(1);
      en_i = 1;
      edges(1);
      chk("R11 restart after enable cycle", outs(), 5'b10010);

      // R12 lockout during negative start
      edges(D10 + 5);
      chk("R3 negative start phase", outs(), 5'b11000);
      uvlo_i = 1;
      edges(1);
      chk("R12 lockout during start", outs(), 5'b00100);
      edges(3);
      chk("R12 held off under lockout", outs(), 5'b00100);
      uvlo_i = 0;
      en_i = 0;
      edges(2);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule